// File: doc/BRIEF.md
# PWM Fault Protection Output Stage

This block sits between a free-running PWM generator and the pins of a group of PWM channels, each with an A and a B output. Four asynchronous fault inputs are each resynchronised, brought to a common "asserted" sense by a per-input polarity setting, and cleaned by a sampling filter. The filter looks at the input once every programmable number of clocks and accepts a new level only after a programmable run of consecutive identical samples. A filtered fault sets a per-input flag. The flag drops by itself in automatic mode, or waits for a software clear pulse in manual mode.

Every output has its own 4-bit mask that selects which flagged faults shut it down. A shut-down output is driven to its own safe state: forced low, forced high, or released with the output enable deasserted. The generator keeps running. Once no masked fault is flagged, the output returns to the generator's value only on a cycle boundary marker. Any boundary is enough, unless one of the faults that caused the shutdown asks for a full-cycle boundary. All configuration arrives as plain input ports.

Top module: `pwm_fault_guard`

## Requirements
- R1: After reset, every fault flag is 0 and every pin carries its generator input with its output enable high.
- R2: While no masked fault is flagged, each pin output follows its generator input in the same cycle, with the output enable at 1.
- R3: Fault input j is asserted when it equals flt_act_hi[j]: bit value 1 means active high and 0 means active low.
- R4: A sample is taken every filt_period clocks (0 and 1 both mean every clock). The filtered level changes only after filt_count consecutive equal samples (0 counts as 1). With period 2 and count 3, a 3-clock pulse is ignored. With period 10 and count 3, a 12-clock pulse is ignored.
- R5: Output k of group A (or B) is shut down only when some fault j has mask bit 4*k+j set and flt_flag[j] = 1. Mask bit j of an output's 4-bit field stands for fault j.
- R6: A shut-down output k is driven from its 2-bit field safe[2k+1:2k]. The value 00 drives 0, 01 drives 1, and 10 or 11 gives output enable 0 with the pin value 0.
- R7: With flt_manual[j] = 0, flt_flag[j] returns to 0 once the filtered fault is inactive, with no clear needed.
- R8: With flt_manual[j] = 1, flt_flag[j] stays set after the filtered fault goes inactive and clears only on a flt_clr[j] pulse. That pulse is ignored while the filtered fault is still active.
- R9: A shut-down output with no masked fault left re-enables only on an edge that samples a boundary pulse. If any fault that took part in the shutdown has flt_full_sel set, only full_cyc_pulse counts. Otherwise half_cyc_pulse or full_cyc_pulse counts.
- R10: On an edge where a boundary pulse meets a masked fault that is flagged (newly or still), the output stays shut down. The fault wins.
- R11: The fault flags are visible on flt_flag, bit j for fault j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flt_raw | input | 4 | Asynchronous fault inputs |
| flt_act_hi | input | 4 | Per-fault polarity, 1 = active high |
| flt_manual | input | 4 | Per-fault clearing mode, 1 = software clear required |
| flt_full_sel | input | 4 | Per-fault re-enable gate, 1 = full-cycle only |
| flt_clr | input | 4 | Write-one-to-clear pulses for the flags |
| filt_period | input | PER_W | Filter sample interval in clocks |
| filt_count | input | CNT_W | Consecutive equal samples required |
| full_cyc_pulse | input | 1 | Full-cycle boundary marker, one clock wide |
| half_cyc_pulse | input | 1 | Half-cycle boundary marker, one clock wide |
| pwm_a_in | input | NUM_CH | Generator A outputs |
| pwm_b_in | input | NUM_CH | Generator B outputs |
| mask_a | input | 4*NUM_CH | Fault masks for A outputs, 4 bits each |
| mask_b | input | 4*NUM_CH | Fault masks for B outputs, 4 bits each |
| safe_a | input | 2*NUM_CH | Safe-state codes for A outputs |
| safe_b | input | 2*NUM_CH | Safe-state codes for B outputs |
| pin_a_out | output | NUM_CH | A pin drive values |
| pin_a_oe | output | NUM_CH | A pin output enables |
| pin_b_out | output | NUM_CH | B pin drive values |
| pin_b_oe | output | NUM_CH | B pin output enables |
| flt_flag | output | 4 | Fault flags |

## Verification
Two functions can fall on the same clock edge: release at a cycle boundary and a fresh shutdown request. To provoke this, the bench lets one fault clear so that an output is waiting for a boundary. It then raises a second masked fault and watches flt_flag until that flag is set. On the following clock it drives a half-cycle pulse, so the boundary lands on the first edge that sees the new request. The output must still show its safe state afterwards, and it may re-enable only on a later boundary once the second fault is gone.

// File: rtl/pwm_fault_guard_pkg.sv
package pwm_fault_guard_pkg;

   localparam int unsigned NUM_FLT = 4;

   typedef struct packed {
      logic drv;
      logic oe;
   } pin_t;

   // Safe-state decode: 00 low, 01 high, 1x released
   function automatic pin_t safe_pin(input logic [1:0] code);
      pin_t p;
      unique case (code)
         2'b00:   p = '{drv: 1'b0, oe: 1'b1};
         2'b01:   p = '{drv: 1'b1, oe: 1'b1};
         default: p = '{drv: 1'b0, oe: 1'b0};
      endcase
      return p;
   endfunction

endpackage

// File: rtl/fp_filter.sv
module fp_filter #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             raw,
   input  logic             act_hi,
   input  logic             tick,
   input  logic [CNT_W-1:0] need_cnt,
   output logic             filt_o
);
   localparam logic [CNT_W-1:0] RUN_MAX = {CNT_W{1'b1}};

   logic             s1, s2, prev;
   logic [CNT_W-1:0] run, run_n, need;

   // polarity applied ahead of the synchroniser so reset means "not asserted"
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1 <= 1'b0;
         s2 <= 1'b0;
      end else begin
         s1 <= raw ^ ~act_hi;
         s2 <= s1;
      end
   end

   always_comb begin
      need = (need_cnt == '0) ? CNT_W'(1) : need_cnt;
      if (s2 == prev)
         run_n = (run == RUN_MAX) ? run : run + CNT_W'(1);
      else
         run_n = CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev   <= 1'b0;
         run    <= '0;
         filt_o <= 1'b0;
      end else if (tick) begin
         prev <= s2;
         run  <= run_n;
         if (run_n >= need)
            filt_o <= s2;
      end
   end
endmodule

// File: rtl/fp_flag.sv
module fp_flag #(
   parameter int unsigned NF = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NF-1:0] filt,
   input  logic [NF-1:0] manual,
   input  logic [NF-1:0] clr,
   output logic [NF-1:0] flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag <= '0;
      else
         flag <= filt | (flag & manual & ~clr);
   end
endmodule

// File: rtl/fp_outgate.sv
module fp_outgate
   import pwm_fault_guard_pkg::*;
#(
   parameter int unsigned NF = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          gen_in,
   input  logic [NF-1:0] mask,
   input  logic [1:0]    safe,
   input  logic [NF-1:0] flag,
   input  logic [NF-1:0] full_sel,
   input  logic          full_pulse,
   input  logic          half_pulse,
   output logic          pin_out,
   output logic          pin_oe,
   output logic          dis_o
);
   logic dis, need_full, req, req_full, bound_ok;
   pin_t sp;

   always_comb begin
      req      = |(mask & flag);
      req_full = |(mask & flag & full_sel);
      bound_ok = full_pulse | (half_pulse & ~need_full);
      sp       = safe_pin(safe);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dis       <= 1'b0;
         need_full <= 1'b0;
      end else if (req) begin
         dis       <= 1'b1;
         need_full <= need_full | req_full;
      end else if (dis && bound_ok) begin
         dis       <= 1'b0;
         need_full <= 1'b0;
      end
   end

   always_comb begin
      pin_out = dis ? sp.drv : gen_in;
      pin_oe  = dis ? sp.oe  : 1'b1;
   end

   assign dis_o = dis;
endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
   import pwm_fault_guard_pkg::*;
#(
   parameter int unsigned NUM_CH = 3,
   parameter int unsigned PER_W  = 8,
   parameter int unsigned CNT_W  = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_FLT-1:0]    flt_raw,
   input  logic [NUM_FLT-1:0]    flt_act_hi,
   input  logic [NUM_FLT-1:0]    flt_manual,
   input  logic [NUM_FLT-1:0]    flt_full_sel,
   input  logic [NUM_FLT-1:0]    flt_clr,
   input  logic [PER_W-1:0]      filt_period,
   input  logic [CNT_W-1:0]      filt_count,
   input  logic                  full_cyc_pulse,
   input  logic                  half_cyc_pulse,
   input  logic [NUM_CH-1:0]     pwm_a_in,
   input  logic [NUM_CH-1:0]     pwm_b_in,
   input  logic [4*NUM_CH-1:0]   mask_a,
   input  logic [4*NUM_CH-1:0]   mask_b,
   input  logic [2*NUM_CH-1:0]   safe_a,
   input  logic [2*NUM_CH-1:0]   safe_b,
   output logic [NUM_CH-1:0]     pin_a_out,
   output logic [NUM_CH-1:0]     pin_a_oe,
   output logic [NUM_CH-1:0]     pin_b_out,
   output logic [NUM_CH-1:0]     pin_b_oe,
   output logic [NUM_FLT-1:0]    flt_flag
);
   localparam int unsigned MW = NUM_FLT;

   if (NUM_CH < 1)  $error("pwm_fault_guard: NUM_CH must be at least 1");
   if (PER_W < 1)   $error("pwm_fault_guard: PER_W must be at least 1");
   if (CNT_W < 1)   $error("pwm_fault_guard: CNT_W must be at least 1");
   if (MW != 4)     $error("pwm_fault_guard: mask fields assume four faults");

   // shared sample-rate prescaler
   logic [PER_W-1:0] pre_cnt;
   logic             tick;

   always_comb
      tick = (filt_period <= PER_W'(1)) || (pre_cnt >= filt_period - PER_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pre_cnt <= '0;
      else if (tick) pre_cnt <= '0;
      else           pre_cnt <= pre_cnt + PER_W'(1);
   end

   logic [NUM_FLT-1:0] filt_vec;

   for (genvar j = 0; j < NUM_FLT; j++) begin : g_flt
      fp_filter #(.CNT_W(CNT_W)) u_filt (
         .clk      (clk),
         .rst_n    (rst_n),
         .raw      (flt_raw[j]),
         .act_hi   (flt_act_hi[j]),
         .tick     (tick),
         .need_cnt (filt_count),
         .filt_o   (filt_vec[j])
      );
   end

   fp_flag #(.NF(NUM_FLT)) u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .filt   (filt_vec),
      .manual (flt_manual),
      .clr    (flt_clr),
      .flag   (flt_flag)
   );

   logic [NUM_CH-1:0] dis_a, dis_b;

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      fp_outgate #(.NF(NUM_FLT)) u_a (
         .clk        (clk),
         .rst_n      (rst_n),
         .gen_in     (pwm_a_in[k]),
         .mask       (mask_a[MW*k +: MW]),
         .safe       (safe_a[2*k +: 2]),
         .flag       (flt_flag),
         .full_sel   (flt_full_sel),
         .full_pulse (full_cyc_pulse),
         .half_pulse (half_cyc_pulse),
         .pin_out    (pin_a_out[k]),
         .pin_oe     (pin_a_oe[k]),
         .dis_o      (dis_a[k])
      );
      fp_outgate #(.NF(NUM_FLT)) u_b (
         .clk        (clk),
         .rst_n      (rst_n),
         .gen_in     (pwm_b_in[k]),
         .mask       (mask_b[MW*k +: MW]),
         .safe       (safe_b[2*k +: 2]),
         .flag       (flt_flag),
         .full_sel   (flt_full_sel),
         .full_pulse (full_cyc_pulse),
         .half_pulse (half_cyc_pulse),
         .pin_out    (pin_b_out[k]),
         .pin_oe     (pin_b_oe[k]),
         .dis_o      (dis_b[k])
      );
   end
endmodule

// File: rtl/pwm_fault_guard_chk.sv
module pwm_fault_guard_chk #(
   parameter int unsigned NUM_CH = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                tick,
   input logic [3:0]          filt,
   input logic [3:0]          flag,
   input logic [3:0]          manual,
   input logic [3:0]          clr,
   input logic                full_p,
   input logic                half_p,
   input logic [4*NUM_CH-1:0] mask_a,
   input logic [4*NUM_CH-1:0] mask_b,
   input logic [NUM_CH-1:0]   dis_a,
   input logic [NUM_CH-1:0]   dis_b
);
   for (genvar j = 0; j < 4; j++) begin : g_f
      assert_filter_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(filt[j]) |-> $past(tick));
      assert_auto_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (!filt[j] && !manual[j]) |=> !flag[j]);
      assert_manual_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (flag[j] && manual[j] && !clr[j]) |=> flag[j]);
      assert_clr_ignored_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
         filt[j] |=> flag[j]);
   end

   for (genvar k = 0; k < NUM_CH; k++) begin : g_o
      assert_fault_wins_a_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (|(mask_a[4*k +: 4] & flag)) |=> dis_a[k]);
      assert_fault_wins_b_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (|(mask_b[4*k +: 4] & flag)) |=> dis_b[k]);
      assert_release_on_boundary_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(dis_a[k]) |-> $past(full_p || half_p));
      assert_release_on_boundary_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(dis_b[k]) |-> $past(full_p || half_p));
   end
endmodule

bind pwm_fault_guard pwm_fault_guard_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .tick   (tick),
   .filt   (filt_vec),
   .flag   (flt_flag),
   .manual (flt_manual),
   .clr    (flt_clr),
   .full_p (full_cyc_pulse),
   .half_p (half_cyc_pulse),
   .mask_a (mask_a),
   .mask_b (mask_b),
   .dis_a  (dis_a),
   .dis_b  (dis_b)
);

// File: tb/sim_pwm_fault_guard.sv
module sim_pwm_fault_guard;
   localparam int NCH = 3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [3:0]     flt_raw = '0, flt_act_hi = 4'hF, flt_manual = '0, flt_full_sel = '0, flt_clr = '0;
   logic [7:0]     filt_period = 8'd2;
   logic [3:0]     filt_count = 4'd3;
   logic           full_p = 1'b0, half_p = 1'b0;
   logic [NCH-1:0] pwm_a = 3'b101, pwm_b = 3'b010;
   logic [4*NCH-1:0] mask_a = '0, mask_b = '0;
   logic [2*NCH-1:0] safe_a = '0, safe_b = '0;
   logic [NCH-1:0] a_out, a_oe, b_out, b_oe;
   logic [3:0]     flag;

   int n_run = 0, n_fail = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   pwm_fault_guard #(.NUM_CH(NCH), .PER_W(8), .CNT_W(4)) u0 (
      .clk(clk), .rst_n(rst_n), .flt_raw(flt_raw), .flt_act_hi(flt_act_hi),
      .flt_manual(flt_manual), .flt_full_sel(flt_full_sel), .flt_clr(flt_clr),
      .filt_period(filt_period), .filt_count(filt_count),
      .full_cyc_pulse(full_p), .half_cyc_pulse(half_p),
      .pwm_a_in(pwm_a), .pwm_b_in(pwm_b), .mask_a(mask_a), .mask_b(mask_b),
      .safe_a(safe_a), .safe_b(safe_b), .pin_a_out(a_out), .pin_a_oe(a_oe),
      .pin_b_out(b_out), .pin_b_oe(b_oe), .flt_flag(flag));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_half();
      half_p = 1'b1; cyc(1); half_p = 1'b0; cyc(1);
   endtask

   task automatic pulse_full();
      full_p = 1'b1; cyc(1); full_p = 1'b0; cyc(1);
   endtask

   task automatic t_reset();
      check("R1 flags", 32'(flag), 0);
      check("R1 a_out", 32'(a_out), 32'(pwm_a));
      check("R1 oe", 32'({a_oe, b_oe}), 32'h3F);
   endtask

   task automatic t_pass();
      pwm_a = 3'b010; pwm_b = 3'b111; cyc(1);
      check("R2 a_out", 32'(a_out), 32'h2);
      check("R2 b_out", 32'(b_out), 32'h7);
      check("R2 oe", 32'({a_oe, b_oe}), 32'h3F);
   endtask

   task automatic t_mask_safe();
      pwm_a = 3'b111; pwm_b = 3'b111;
      mask_a = {4'b0010, 4'b0001, 4'b0001};
      mask_b = {4'b0000, 4'b0000, 4'b0100};
      safe_a = {2'b10, 2'b01, 2'b00};
      safe_b = {2'b00, 2'b00, 2'b11};
      flt_raw[0] = 1'b1; cyc(20);
      check("R11 flag fault0", 32'(flag), 32'h1);
      check("R5 R6 a_out", 32'(a_out), 32'h6);
      check("R6 a_oe", 32'(a_oe), 32'h7);
      check("R5 b_oe untouched", 32'(b_oe), 32'h7);
      flt_raw[2] = 1'b1; cyc(20);
      check("R6 tristate b0", 32'({b_oe, b_out}), 32'h36);
      flt_raw = '0; cyc(20);
      check("R7 auto release", 32'(flag), 0);
      check("R9 held until boundary", 32'(a_out), 32'h6);
      pulse_half();
      check("R9 half boundary a", 32'(a_out), 32'h7);
      check("R9 half boundary b", 32'({b_oe, b_out}), 32'h3F);
   endtask

   task automatic t_filter();
      flt_raw[1] = 1'b1; cyc(3); flt_raw[1] = 1'b0; cyc(20);
      check("R4 short pulse", 32'(flag), 0);
      check("R4 output kept", 32'(a_oe), 32'h7);
      filt_period = 8'd10;
      flt_raw[1] = 1'b1; cyc(12); flt_raw[1] = 1'b0; cyc(60);
      check("R4 slow period", 32'(flag), 0);
      filt_period = 8'd2;
      flt_raw[1] = 1'b1; cyc(20);
      check("R4 long pulse", 32'(flag), 32'h2);
      check("R6 hiz a2", 32'({a_oe[2], a_out[2]}), 32'h0);
      flt_raw[1] = 1'b0; cyc(20); pulse_half();
      check("R9 release", 32'(a_oe), 32'h7);
   endtask

   task automatic t_polarity();
      flt_act_hi[3] = 1'b0; flt_raw[3] = 1'b1; cyc(20);
      check("R3 low-active idle", 32'(flag), 0);
      flt_raw[3] = 1'b0; cyc(20);
      check("R3 low-active fault", 32'(flag), 32'h8);
      flt_raw[3] = 1'b1; cyc(20);
      check("R3 release", 32'(flag), 0);
   endtask

   task automatic t_manual();
      flt_manual[0] = 1'b1;
      flt_raw[0] = 1'b1; cyc(20);
      check("R8 set", 32'(flag[0]), 1);
      flt_clr[0] = 1'b1; cyc(1); flt_clr[0] = 1'b0; cyc(2);
      check("R8 clr ignored while active", 32'(flag[0]), 1);
      flt_raw[0] = 1'b0; cyc(20);
      check("R8 sticky", 32'(flag[0]), 1);
      pulse_half();
      check("R8 output held", 32'(a_out), 32'h6);
      flt_clr[0] = 1'b1; cyc(1); flt_clr[0] = 1'b0; cyc(1);
      check("R8 cleared", 32'(flag[0]), 0);
      pulse_half();
      check("R9 after clear", 32'(a_out), 32'h7);
      flt_manual[0] = 1'b0;
   endtask

   task automatic t_full();
      flt_full_sel[0] = 1'b1;
      flt_raw[0] = 1'b1; cyc(20); flt_raw[0] = 1'b0; cyc(20);
      check("R7 flag dropped", 32'(flag), 0);
      pulse_half();
      check("R9 half ignored", 32'(a_out), 32'h6);
      pulse_full();
      check("R9 full boundary", 32'(a_out), 32'h7);
      flt_full_sel[0] = 1'b0;
   endtask

   task automatic t_coincide();
      int guard;
      mask_a[3:0] = 4'b0011;
      flt_raw[0] = 1'b1; cyc(20); flt_raw[0] = 1'b0; cyc(20);
      check("R10 waiting", 32'(a_out[0]), 0);
      flt_raw[1] = 1'b1;
      guard = 0;
      while (!flag[1] && guard < 100) begin cyc(1); guard++; end
      pulse_half();
      check("R10 fault wins over boundary", 32'(a_out[0]), 0);
      flt_raw[1] = 1'b0; cyc(20);
      check("R10 still held", 32'(a_out[0]), 0);
      pulse_half();
      check("R10 release later", 32'(a_out[0]), 1);
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      cyc(3);
      t_reset();
      rst_n = 1'b1; cyc(2);
      t_reset();
      t_pass();
      t_mask_safe();
      t_filter();
      t_polarity();
      t_manual();
      t_full();
      t_coincide();
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule